// File: doc/BRIEF.md
# Configurable Serial Audio Input Port

This block receives stereo PCM audio over three wires: a bit clock, a word clock whose level marks the left or right channel, and a serial data line. Every signal is oversampled by the system clock through two-flop synchronizers. Each phase of the word clock is decoded into a parallel sample word, and a one-cycle strobe is raised once a left word and the right word after it are both available. One receiver handles left-justified, I2S-style and right-justified framing. Justification, a one-bit start delay, and the polarity of each clock are independent runtime controls.

In slave mode the two clocks come from pins. The bit clock may pause between bursts, and the two word-clock phases may differ in length. In master mode the block generates both clocks itself by dividing the system clock and drives them out, while the data still arrives on the data pin. The system clock must run at least four times faster than the bit clock.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is high and after it is released, `left_out`, `right_out`, `valid`, `bclk_out` and `wclk_out` are all 0.
- R2: Data is sampled on rising edges of the normalised bit clock, which is the pin level XOR `cfg_bclk_inv`. A normalised word-clock level of 1 (pin level XOR `cfg_wclk_inv`) marks the left channel. With `cfg_rjust`=0, the first sampled bit of a phase is the MSB of the word.
- R3: With `cfg_delay`=1, the first bit-clock cell of each phase is skipped, so the MSB is taken from the second cell.
- R4: Setting `cfg_bclk_inv` moves sampling to falling pin edges. Setting `cfg_wclk_inv` makes a low pin level mean left. Both work independently.
- R5: With `cfg_rjust`=1, the last N bits of a phase form the sample. They are placed in the top N bits of the output word, with the lower bits zero.
- R6: The resolution code `cfg_res` gives N: 00=24, 01=20, 10=16, 11=18. With left justification, the bits below the top N are zeroed.
- R7: With code 00 and left justification, a phase of fewer than 24 data bits gives a zero-filled word, and a longer phase keeps its first 24 bits.
- R8: `valid` pulses for one cycle for each left phase followed by a right phase. The pulse comes at the first sampling edge of the next phase, and both words update in that same cycle and are held until the next pulse. After reset, the phase in progress is discarded, because its start was not observed.
- R9: In slave mode, a bit clock that stops mid-phase and left and right phases of unequal length are both decoded correctly.
- R10: In master mode, `bclk_out` has a period of 2*(`cfg_div`+1) system clocks, and `wclk_out` toggles once every PHASE_BITS bit-clock periods, starting left. Both pins include their polarity inversion. In slave mode both pins are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = generate clocks, 0 = take clocks from pins |
| cfg_div | input | DIV_W | Bit clock half period minus one, in system clocks |
| cfg_res | input | 2 | Resolution code |
| cfg_rjust | input | 1 | 1 = right justified |
| cfg_delay | input | 1 | 1 = skip first bit cell of each phase |
| cfg_bclk_inv | input | 1 | Invert bit clock polarity |
| cfg_wclk_inv | input | 1 | Invert word clock polarity |
| bclk_in | input | 1 | Bit clock pin in slave mode |
| wclk_in | input | 1 | Word clock pin in slave mode |
| sdata | input | 1 | Serial data |
| bclk_out | output | 1 | Generated bit clock in master mode |
| wclk_out | output | 1 | Generated word clock in master mode |
| left_out | output | SAMPLE_W | Left sample word |
| right_out | output | SAMPLE_W | Right sample word |
| valid | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The hardest condition to create from the ports is a bit clock that stops in the middle of a phase while the two phases have different lengths. Under that condition the right word only completes when the next left phase begins. The bench's pin-level transmitter can stretch any chosen low half-cell and set each phase length separately. It always ends a stream with a short extra left phase, so that the last pair is flushed. Master mode needs data that follows clocks the block produces itself. A reactive process in the bench watches the output pins, counts bit cells from each word-clock change, and drives the next bit on every falling edge.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  typedef enum logic [1:0] {
    RES_24 = 2'b00,
    RES_20 = 2'b01,
    RES_16 = 2'b10,
    RES_18 = 2'b11
  } res_e;

  // number of significant bits selected by a resolution code
  function automatic int res_len(input logic [1:0] code);
    case (res_e'(code))
      RES_24:  return 24;
      RES_20:  return 20;
      RES_16:  return 16;
      default: return 18;
    endcase
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) st[g] <= '0;
          else     st[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) st[g] <= '0;
          else     st[g] <= st[g-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];

endmodule

// File: rtl/sarx_clkgen.sv
module sarx_clkgen #(
  parameter int DIV_W      = 8,
  parameter int PHASE_BITS = 32,
  localparam int BCNT_W    = (PHASE_BITS > 1) ? $clog2(PHASE_BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             gen_bclk,
  output logic             gen_left
);

  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(PHASE_BITS - 1);

  logic [DIV_W-1:0]  cnt;
  logic [BCNT_W-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt      <= '0;
      bitcnt   <= '0;
      gen_bclk <= 1'b0;
      gen_left <= 1'b1;
    end else if (cnt >= div) begin
      cnt      <= '0;
      gen_bclk <= ~gen_bclk;
      if (gen_bclk) begin
        // falling edge of the bit clock: phase boundaries sit here
        if (bitcnt == LAST_BIT) begin
          bitcnt   <= '0;
          gen_left <= ~gen_left;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R10
  wclk_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$stable(gen_left)) |-> $fell(gen_bclk));

endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_rise,
  input  logic                sd_bit,
  input  logic                ch_left,
  input  logic                cfg_rjust,
  input  logic                cfg_delay,
  input  logic [1:0]          cfg_res,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                valid
);

  localparam logic [SAMPLE_W-1:0] ONES = '1;
  localparam logic [CNT_W-1:0]    FULL = CNT_W'(SAMPLE_W);

  logic                have_prev, prev_left, phase_ok, left_have;
  logic [SAMPLE_W-1:0] acc, sr, left_hold;
  logic [CNT_W-1:0]    n;

  logic                new_phase, take;
  logic [SAMPLE_W-1:0] base_acc, base_sr, acc_n, sr_n;
  logic [CNT_W-1:0]    base_n, n_n;
  logic [SAMPLE_W-1:0] hi_mask, lo_mask, word;
  int                  res_n;

  always_comb begin
    new_phase = !have_prev || (ch_left != prev_left);
    take      = !(new_phase && cfg_delay);
    base_acc  = new_phase ? '0 : acc;
    base_sr   = new_phase ? '0 : sr;
    base_n    = new_phase ? '0 : n;
    acc_n     = base_acc;
    n_n       = base_n;
    sr_n      = base_sr;
    if (take) begin
      sr_n = {base_sr[SAMPLE_W-2:0], sd_bit};
      if (base_n < FULL) begin
        acc_n = base_acc |
                ({{(SAMPLE_W-1){1'b0}}, sd_bit} << (SAMPLE_W - 1 - int'(base_n)));
        n_n   = base_n + 1'b1;
      end
    end
    res_n   = res_len(cfg_res);
    hi_mask = ~(ONES >> res_n);
    lo_mask = ONES >> (SAMPLE_W - res_n);
    // word of the phase that is closing (old acc/sr)
    word    = cfg_rjust ? ((sr & lo_mask) << (SAMPLE_W - res_n))
                        : (acc & hi_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_prev <= 1'b0;
      prev_left <= 1'b0;
      phase_ok  <= 1'b0;
      left_have <= 1'b0;
      acc       <= '0;
      sr        <= '0;
      n         <= '0;
      left_hold <= '0;
      left_out  <= '0;
      right_out <= '0;
      valid     <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (bit_rise) begin
        have_prev <= 1'b1;
        prev_left <= ch_left;
        acc       <= acc_n;
        sr        <= sr_n;
        n         <= n_n;
        if (new_phase) phase_ok <= have_prev;
        if (new_phase && have_prev && phase_ok) begin
          if (prev_left) begin
            left_hold <= word;
            left_have <= 1'b1;
          end else begin
            left_have <= 1'b0;
            if (left_have) begin
              left_out  <= left_hold;
              right_out <= word;
              valid     <= 1'b1;
            end
          end
        end
      end
    end
  end

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    n <= FULL);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W   = 24,
  parameter int DIV_W      = 8,
  parameter int PHASE_BITS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_master,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_res,
  input  logic                cfg_rjust,
  input  logic                cfg_delay,
  input  logic                cfg_bclk_inv,
  input  logic                cfg_wclk_inv,
  input  logic                bclk_in,
  input  logic                wclk_in,
  input  logic                sdata,
  output logic                bclk_out,
  output logic                wclk_out,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                valid
);

  logic gen_bclk, gen_left;
  logic raw_b, raw_w;
  logic [2:0] sync_q;
  logic b_prev, bit_rise;

  sarx_clkgen #(
    .DIV_W      (DIV_W),
    .PHASE_BITS (PHASE_BITS)
  ) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_master),
    .div      (cfg_div),
    .gen_bclk (gen_bclk),
    .gen_left (gen_left)
  );

  // normalised clocks: bit rising = sample, word high = left
  always_comb begin
    raw_b = cfg_master ? gen_bclk : (bclk_in ^ cfg_bclk_inv);
    raw_w = cfg_master ? gen_left : (wclk_in ^ cfg_wclk_inv);
  end

  sarx_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({raw_b, raw_w, sdata}),
    .q   (sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) b_prev <= 1'b0;
    else     b_prev <= sync_q[2];
  end
  assign bit_rise = sync_q[2] & ~b_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_out <= 1'b0;
      wclk_out <= 1'b0;
    end else begin
      bclk_out <= cfg_master & (gen_bclk ^ cfg_bclk_inv);
      wclk_out <= cfg_master & (gen_left ^ cfg_wclk_inv);
    end
  end

  sarx_deser #(
    .SAMPLE_W (SAMPLE_W)
  ) u_deser (
    .clk       (clk),
    .rst       (rst),
    .bit_rise  (bit_rise),
    .sd_bit    (sync_q[0]),
    .ch_left   (sync_q[1]),
    .cfg_rjust (cfg_rjust),
    .cfg_delay (cfg_delay),
    .cfg_res   (cfg_res),
    .left_out  (left_out),
    .right_out (right_out),
    .valid     (valid)
  );

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R8
  words_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(left_out) || !$stable(right_out)) |-> valid);

  // R10
  slave_pins_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |=> (!bclk_out && !wclk_out));

endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

  localparam int PHASE_BITS = 32;
  localparam logic [23:0] ML = 24'hA5C3F1;
  localparam logic [23:0] MR = 24'h3C5A0E;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_master = 1'b0;
  logic [7:0] cfg_div = 8'd2;
  logic [1:0] cfg_res = 2'b00;
  logic cfg_rjust = 1'b0, cfg_delay = 1'b0, cfg_bclk_inv = 1'b0, cfg_wclk_inv = 1'b0;
  logic bclk_in = 1'b0, wclk_in = 1'b0, sdata = 1'b0;
  logic bclk_out, wclk_out, valid;
  logic [23:0] left_out, right_out;

  serial_audio_rx #(.SAMPLE_W(24), .DIV_W(8), .PHASE_BITS(PHASE_BITS)) u_serial_audio_rx (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_div(cfg_div), .cfg_res(cfg_res),
    .cfg_rjust(cfg_rjust), .cfg_delay(cfg_delay), .cfg_bclk_inv(cfg_bclk_inv),
    .cfg_wclk_inv(cfg_wclk_inv), .bclk_in(bclk_in), .wclk_in(wclk_in), .sdata(sdata),
    .bclk_out(bclk_out), .wclk_out(wclk_out), .left_out(left_out),
    .right_out(right_out), .valid(valid)
  );

  int tests = 0, fails = 0;
  int H = 2;
  int cyc = 0;
  int mvalids = 0;
  bit done = 1'b0, master_phase = 1'b0, master_tx = 1'b0;
  string cur_req = "R2";
  logic [23:0] exp_l_q[$], exp_r_q[$];
  logic [23:0] held_l = '0, held_r = '0;
  logic prev_valid = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [63:0] word, input int w,
                                              input bit rj, input logic [1:0] res);
    int n;
    logic [63:0] v;
    n = (res == 2'b00) ? 24 : (res == 2'b01) ? 20 : (res == 2'b10) ? 16 : 18;
    if (rj) begin
      v = word & ((64'd1 << n) - 64'd1);
      v = v << (24 - n);
      return v[23:0];
    end
    v = (w <= 24) ? (word << (24 - w)) : (word >> (w - 24));
    return v[23:0] & ~(24'hFFFFFF >> n);
  endfunction

  // per-clock reference comparison (R8 timing/holding, data per section tag)
  always @(negedge clk) begin
    if (rst) begin
      held_l     = '0;
      held_r     = '0;
      prev_valid = 1'b0;
    end else if (!done) begin
      if (valid && prev_valid) chk(1'b0, "R8", 64'd1, 64'd0);
      if (valid) begin
        if (master_phase) begin
          chk(left_out === ML, "R10", {40'd0, left_out}, {40'd0, ML});
          chk(right_out === MR, "R10", {40'd0, right_out}, {40'd0, MR});
          mvalids++;
        end else if (exp_l_q.size() == 0) begin
          chk(1'b0, "R8", {40'd0, left_out}, 64'd0);
        end else begin
          logic [23:0] el, er;
          el = exp_l_q.pop_front();
          er = exp_r_q.pop_front();
          chk(left_out === el, cur_req, {40'd0, left_out}, {40'd0, el});
          chk(right_out === er, cur_req, {40'd0, right_out}, {40'd0, er});
        end
        held_l = left_out;
        held_r = right_out;
      end else if (left_out !== held_l || right_out !== held_r) begin
        chk(1'b0, "R8", {16'd0, left_out, right_out}, {16'd0, held_l, held_r});
      end
      prev_valid = valid;
    end
  end

  // reactive transmitter for master mode (R10)
  bit mprev_b = 1'b0, mprev_w = 1'b1;
  int mslot = 0;
  always @(negedge clk) begin
    if (master_tx) begin
      bit nb, nw;
      nb = bclk_out ^ cfg_bclk_inv;
      nw = wclk_out ^ cfg_wclk_inv;
      if (mprev_b && !nb) begin
        if (nw != mprev_w) mslot = 0;
        else mslot++;
        if (mslot < 24) sdata = nw ? ML[23 - mslot] : MR[23 - mslot];
        else sdata = 1'b0;
      end
      mprev_b = nb;
      mprev_w = nw;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bclk_in = cfg_bclk_inv;
    wclk_in = cfg_wclk_inv;
    sdata = 1'b0;
    exp_l_q.delete();
    exp_r_q.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_phase(input bit left, input logic [63:0] word, input int w,
                            input int p, input int gap_at);
    for (int s = 0; s < p; s++) begin
      int idx;
      bit b;
      idx = cfg_rjust ? s - (p - w) : s - (cfg_delay ? 1 : 0);
      b = (idx >= 0 && idx < w) ? word[w - 1 - idx] : 1'b0;
      @(negedge clk);
      if (s == 0) wclk_in = left ^ cfg_wclk_inv;
      bclk_in = cfg_bclk_inv;
      sdata = b;
      repeat (H - 1 + ((s == gap_at) ? 25 : 0)) @(negedge clk);
      @(negedge clk);
      bclk_in = ~cfg_bclk_inv;
      repeat (H - 1) @(negedge clk);
    end
  endtask

  task automatic send_pair(input logic [63:0] l, input logic [63:0] r, input int w,
                           input int pl, input int pr, input int gap);
    exp_l_q.push_back(expect_word(l, w, cfg_rjust, cfg_res));
    exp_r_q.push_back(expect_word(r, w, cfg_rjust, cfg_res));
    send_phase(1'b1, l, w, pl, gap);
    send_phase(1'b0, r, w, pr, -1);
  endtask

  task automatic open_stream(input string req, input bit rj, input bit dly,
                             input bit binv, input bit winv, input logic [1:0] res);
    cur_req = req;
    cfg_master = 1'b0;
    cfg_rjust = rj;
    cfg_delay = dly;
    cfg_bclk_inv = binv;
    cfg_wclk_inv = winv;
    cfg_res = res;
    do_reset();
    send_phase(1'b0, 64'd0, 0, 4, -1); // partial right phase, discarded (R8)
  endtask

  task automatic close_stream();
    send_phase(1'b1, 64'd0, 0, 2, -1);
    repeat (12) @(negedge clk);
    chk(exp_l_q.size() == 0, "R8", 64'(exp_l_q.size()), 64'd0);
  endtask

  task automatic wait_bclk_rise(output int t);
    logic last;
    last = bclk_out;
    forever begin
      @(negedge clk);
      if (bclk_out && !last) break;
      last = bclk_out;
    end
    t = cyc;
  endtask

  task automatic wait_wclk_change(output int t);
    logic last;
    last = wclk_out;
    forever begin
      @(negedge clk);
      if (wclk_out !== last) break;
    end
    t = cyc;
  endtask

  initial begin
    int t0, t1;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(left_out === 24'd0 && right_out === 24'd0, "R1", {16'd0, left_out, right_out}, 64'd0);
    chk(valid === 1'b0 && bclk_out === 1'b0 && wclk_out === 1'b0, "R1",
        {61'd0, valid, bclk_out, wclk_out}, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(left_out === 24'd0 && valid === 1'b0, "R1", {39'd0, valid, left_out}, 64'd0);

    // R2: left justified, 24-bit words
    open_stream("R2", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    chk(bclk_out === 1'b0 && wclk_out === 1'b0, "R10", {62'd0, bclk_out, wclk_out}, 64'd0);
    send_pair(64'hABCDEF, 64'h123456, 24, 32, 32, -1);
    send_pair(64'h800001, 64'h7FFFFE, 24, 32, 32, -1);
    send_pair(64'hFFFFFF, 64'h000000, 24, 32, 32, -1);
    send_pair(64'h5A5A5A, 64'hC3C3C3, 24, 32, 32, -1);
    close_stream();

    // R3: one-cell delay with inverted word clock (I2S style)
    open_stream("R3", 1'b0, 1'b1, 1'b0, 1'b1, 2'b00);
    send_pair(64'h9ABCDE, 64'h13579B, 24, 32, 32, -1);
    send_pair(64'h800000, 64'h000001, 24, 32, 32, -1);
    send_pair(64'h2468AC, 64'hFEDCBA, 24, 32, 32, -1);
    close_stream();

    // R4: inverted bit clock, then both inverted
    open_stream("R4", 1'b0, 1'b0, 1'b1, 1'b0, 2'b00);
    send_pair(64'h0F1E2D, 64'hC0FFEE, 24, 28, 28, -1);
    send_pair(64'h112233, 64'h445566, 24, 28, 28, -1);
    close_stream();
    open_stream("R4", 1'b0, 1'b0, 1'b1, 1'b1, 2'b00);
    send_pair(64'h778899, 64'hAABBCC, 24, 28, 28, -1);
    close_stream();

    // R5: right justified, 16/18/20 bits
    open_stream("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'b10);
    send_pair(64'hBEEF, 64'h8001, 16, 32, 32, -1);
    send_pair(64'h7FFF, 64'h1234, 16, 32, 32, -1);
    close_stream();
    open_stream("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'b11);
    send_pair(64'hFACE77, 64'h3FFFF, 24, 30, 30, -1);
    close_stream();
    open_stream("R5", 1'b1, 1'b0, 1'b0, 1'b0, 2'b01);
    send_pair(64'hABCDE, 64'h80001, 20, 20, 20, -1);
    close_stream();

    // R6: left justified with 20 and 18 bit resolution
    open_stream("R6", 1'b0, 1'b0, 1'b0, 1'b0, 2'b01);
    send_pair(64'hFFFFFF, 64'h12345F, 24, 32, 32, -1);
    close_stream();
    open_stream("R6", 1'b0, 1'b0, 1'b0, 1'b0, 2'b11);
    send_pair(64'hFFFFFF, 64'hABCDEF, 24, 32, 32, -1);
    close_stream();

    // R7: short words zero-filled, long words truncated
    open_stream("R7", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    send_pair(64'hCAFE, 64'h8001, 16, 20, 20, -1);
    send_pair(64'hDEADBEEF, 64'h87654321, 32, 40, 40, -1);
    close_stream();

    // R9: stopped bit clock, unequal phases, slower bit clock
    H = 3;
    open_stream("R9", 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
    send_pair(64'h3D5E7F, 64'hA1B2C3, 24, 25, 40, 10);
    send_pair(64'h010203, 64'hF0E0D0, 24, 25, 40, 0);
    close_stream();
    H = 2;

    // R10: master mode
    cur_req = "R10";
    cfg_rjust = 1'b0; cfg_delay = 1'b0; cfg_res = 2'b00;
    cfg_bclk_inv = 1'b0; cfg_wclk_inv = 1'b0; cfg_div = 8'd2;
    master_phase = 1'b1;
    @(negedge clk); rst = 1'b1; cfg_master = 1'b1; mslot = 0; mprev_b = 1'b0; mprev_w = 1'b1;
    repeat (3) @(negedge clk);
    master_tx = 1'b1;
    rst = 1'b0;
    t0 = cyc;
    while (mvalids < 3 && cyc - t0 < 5000) @(negedge clk);
    chk(mvalids >= 3, "R10", 64'(mvalids), 64'd3);
    wait_bclk_rise(t0);
    wait_bclk_rise(t1);
    chk(t1 - t0 == 6, "R10", 64'(t1 - t0), 64'd6);
    wait_wclk_change(t0);
    wait_wclk_change(t1);
    chk(t1 - t0 == PHASE_BITS * 6, "R10", 64'(t1 - t0), 64'(PHASE_BITS * 6));
    @(negedge clk);
    rst = 1'b1;
    master_tx = 1'b0;
    cfg_master = 1'b0;
    repeat (3) @(negedge clk);
    master_phase = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(bclk_out === 1'b0 && wclk_out === 1'b0, "R10", {62'd0, bclk_out, wclk_out}, 64'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule